// File: doc/BRIEF.md
# Three-wire serial EEPROM target

This block is a cycle-synchronous model of a small serial EEPROM that answers a three-wire host: a chip select, a serial clock and a data input, with one data output that has its own drive enable. The serial pins are sampled by the system clock, and a rising serial clock is detected as a one-cycle event. Each command is a start bit, a two-bit opcode and an address, followed by a data word for the writing commands. The storage is a byte array that can be viewed either as bytes or as 16-bit words, selected by a width input.

Reads stream data out MSB first behind one leading zero, and they keep going through consecutive addresses while select stays high. Programming commands (single-word write and erase, fill-all and clear-all, lock and unlock) change the array at once. They then run a programming timer of fixed length. While that timer runs, the host can poll ready or busy on the output line by dropping select and raising it again.

The controller walks through these states. `ST_IDLE` waits for a start bit. `ST_OPC` collects the two opcode bits. `ST_ADR` collects the address. `ST_DAT` collects a data word. `ST_READ` shifts read data out. `ST_STAT` drives ready or busy. `ST_HOLD` ignores the line until select falls.

The transitions are:
- ST_IDLE to ST_OPC when a 1 is clocked in.
- ST_OPC to ST_ADR after two opcode bits.
- ST_ADR to ST_READ for a read.
- ST_ADR to ST_DAT for write or fill-all.
- ST_ADR to ST_HOLD for erase, clear-all, lock and unlock.
- ST_DAT to ST_HOLD after the last data bit.
- Any state to ST_IDLE whenever select is low.
- ST_IDLE to ST_STAT on a select rise that follows a long enough low time while the timer runs.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low, programming is locked and every byte of the array reads 0xFF.
- R2: With select high, a command starts at the first rising serial clock that samples a 1 on the data input; 0 bits before it are skipped. Opcode bits, first bit first, are 10 read, 01 write, 11 erase and 00 extended. A select low at any point abandons a command that is not yet complete, and the array is left untouched.
- R3: With the width input low, words are 8 bits and the address is 9 bits. With it high, words are 16 bits and the address is 8 bits, and word n is byte 2n (upper half) followed by byte 2n+1.
- R4: On the rising clock that samples the last address bit of a read, the output is enabled and drives 0. Each following rising clock presents the next data bit, MSB first. Read data changes only after a rising serial clock.
- R5: While select stays high, the word after the last bit of a read word is the word at the next address, with no extra 0 between them. The address wraps from the top of the array to 0.
- R6: Under the extended opcode, the two most significant address bits select the command: 11 unlocks programming and 00 locks it. The other address bits are clocked in but ignored. Write, erase, fill-all and clear-all have no effect while programming is locked.
- R7: A write stores the data word that follows the address, with no prior erase needed.
- R8: An erase sets every bit of the addressed word to 1.
- R9: Extended selector 01 followed by a data word fills every word with that pattern. Selector 10 sets the whole array to ones. Both take effect only while the supply-ok input is high.
- R10: A program command that is accepted starts a timer of PROG_CYCLES system clocks. Program commands that complete while the timer runs are ignored.
- R11: If select has been low for at least CS_LOW_MIN clocks and then rises while the timer runs, the output is enabled and drives 0 while busy, then 1 once the timer ends. It holds that until select falls.
- R12: A select rise after the timer has finished leaves the output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdin | input | 1 | Serial data input |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| supply_ok | input | 1 | Enables fill-all and clear-all |
| sdout | output | 1 | Serial data or ready/busy status |
| sdout_oe | output | 1 | Drive enable for sdout |

## Verification
The bench uses the default 9-bit byte address, PROG_CYCLES of 100 and CS_LOW_MIN of 3. With the full 512-byte array, it writes every location with a distinct byte and reads all of them back as one unbroken stream in both widths, past the top address, so the wrap and the byte pairing of 16-bit words are both seen. The 100-cycle timer is long enough that a second command and a status poll both land inside one busy window. Locked, low-supply and aborted commands are then each followed by a read-back of the bytes they could have touched.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_READ,
        ST_STAT,
        ST_HOLD
    } mw_state_e;

    typedef enum logic [1:0] {
        OP_EXT   = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } mw_op_e;

    typedef enum logic [1:0] {
        EX_LOCK   = 2'b00,
        EX_FILL   = 2'b01,
        EX_CLEAR  = 2'b10,
        EX_UNLOCK = 2'b11
    } mw_ext_e;

endpackage

// File: rtl/mw_edge.sv
module mw_edge #(
    parameter int CS_LOW_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    output logic sk_rise,
    output logic cs_rise,
    output logic low_ok
);
    localparam int LOW_W = $clog2(CS_LOW_MIN + 2);
    localparam logic [LOW_W-1:0] LOW_SAT = LOW_W'(CS_LOW_MIN);

    logic             sk_q;
    logic             cs_q;
    logic [LOW_W-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q    <= 1'b0;
            cs_q    <= 1'b0;
            low_cnt <= '0;
        end else begin
            sk_q <= sclk;
            cs_q <= sel;
            if (!sel) begin
                if (low_cnt != LOW_SAT) low_cnt <= low_cnt + 1'b1;
            end else if (cs_q) begin
                low_cnt <= '0;
            end
        end
    end

    assign sk_rise = sclk & ~sk_q;
    assign cs_rise = sel & ~cs_q;
    assign low_ok  = (low_cnt == LOW_SAT);

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start) begin
            remain <= CNT_W'(PROG_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int BYTE_AW = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               org_wide,
    input  logic [BYTE_AW-1:0] rd_addr,
    output logic [15:0]        rd_word,
    input  logic               wr_en,
    input  logic [BYTE_AW-1:0] wr_addr,
    input  logic [15:0]        wr_word,
    input  logic               fill_en,
    input  logic [15:0]        fill_word
);
    localparam int NBYTES = 1 << BYTE_AW;

    logic [7:0] mem [NBYTES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
        end else if (fill_en) begin
            for (int i = 0; i < NBYTES; i++)
                mem[i] <= (org_wide && (i % 2 == 0)) ? fill_word[15:8] : fill_word[7:0];
        end else if (wr_en) begin
            if (org_wide) begin
                mem[{wr_addr[BYTE_AW-2:0], 1'b0}] <= wr_word[15:8];
                mem[{wr_addr[BYTE_AW-2:0], 1'b1}] <= wr_word[7:0];
            end else begin
                mem[wr_addr] <= wr_word[7:0];
            end
        end
    end

    always_comb begin
        if (org_wide)
            rd_word = {mem[{rd_addr[BYTE_AW-2:0], 1'b0}], mem[{rd_addr[BYTE_AW-2:0], 1'b1}]};
        else
            rd_word = {8'h00, mem[rd_addr]};
    end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int BYTE_AW     = 9,
    parameter int PROG_CYCLES = 200,
    parameter int CS_LOW_MIN  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdin,
    input  logic org_wide,
    input  logic supply_ok,
    output logic sdout,
    output logic sdout_oe
);
    localparam logic [4:0] AW_NARROW = 5'(BYTE_AW);
    localparam logic [4:0] AW_WIDE   = 5'(BYTE_AW - 1);
    localparam logic [BYTE_AW-1:0] ADDR_ONE = BYTE_AW'(1);

    mw_state_e          state;
    logic [1:0]         opc;
    logic [4:0]         bit_cnt;
    logic [BYTE_AW-1:0] addr;
    logic [15:0]        data;
    logic               prog_en;
    logic [BYTE_AW-1:0] rptr;
    logic [4:0]         rd_idx;
    logic               dout_r;

    logic sk_rise, cs_rise, low_ok, busy;
    logic wr_en, fill_en, tmr_start, rd_active;
    logic [15:0]        rd_word, wr_word, fill_word;
    logic [BYTE_AW-1:0] wr_addr;

    logic [4:0]         aw_cur, wd_cur;
    logic [BYTE_AW-1:0] addr_nx, waddr_nx, rptr_inc;
    logic [15:0]        data_nx;
    logic [1:0]         ext_nx, ext_now;
    logic               step, last_adr, last_dat, can_prog;
    logic [3:0]         rd_bit;

    mw_edge #(.CS_LOW_MIN(CS_LOW_MIN)) edge_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk),
        .sk_rise(sk_rise), .cs_rise(cs_rise), .low_ok(low_ok)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(busy)
    );

    mw_array #(.BYTE_AW(BYTE_AW)) array_i (
        .clk(clk), .rst_n(rst_n), .org_wide(org_wide),
        .rd_addr(rptr), .rd_word(rd_word),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
        .fill_en(fill_en), .fill_word(fill_word)
    );

    // Shared decode terms
    always_comb begin
        aw_cur   = org_wide ? AW_WIDE : AW_NARROW;
        wd_cur   = org_wide ? 5'd16 : 5'd8;
        addr_nx  = {addr[BYTE_AW-2:0], sdin};
        data_nx  = {data[14:0], sdin};
        waddr_nx = org_wide ? {1'b0, addr_nx[BYTE_AW-2:0]} : addr_nx;
        ext_nx   = org_wide ? addr_nx[BYTE_AW-2 -: 2] : addr_nx[BYTE_AW-1 -: 2];
        ext_now  = org_wide ? addr[BYTE_AW-2 -: 2] : addr[BYTE_AW-1 -: 2];
        rptr_inc = org_wide ? {1'b0, rptr[BYTE_AW-2:0] + ADDR_ONE[BYTE_AW-2:0]}
                            : rptr + ADDR_ONE;
        step     = sel && sk_rise && !cs_rise;
        last_adr = step && (state == ST_ADR) && (bit_cnt == aw_cur - 5'd1);
        last_dat = step && (state == ST_DAT) && (bit_cnt == wd_cur - 5'd1);
        can_prog = prog_en && !busy;
        rd_bit   = 4'(rd_idx - 5'd1);
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            opc     <= '0;
            bit_cnt <= '0;
            addr    <= '0;
            data    <= '0;
            prog_en <= 1'b0;
            rptr    <= '0;
            rd_idx  <= '0;
            dout_r  <= 1'b0;
        end else if (!sel) begin
            state <= ST_IDLE;
        end else if (cs_rise) begin
            state <= (busy && low_ok) ? ST_STAT : ST_IDLE;
        end else if (sk_rise) begin
            unique case (state)
                ST_IDLE: begin
                    if (sdin) begin
                        state   <= ST_OPC;
                        bit_cnt <= '0;
                    end
                end
                ST_OPC: begin
                    opc <= {opc[0], sdin};
                    if (bit_cnt == 5'd1) begin
                        state   <= ST_ADR;
                        bit_cnt <= '0;
                        addr    <= '0;
                    end else begin
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                end
                ST_ADR: begin
                    addr <= addr_nx;
                    if (last_adr) begin
                        bit_cnt <= '0;
                        data    <= '0;
                        unique case (mw_op_e'(opc))
                            OP_READ: begin
                                state  <= ST_READ;
                                rptr   <= waddr_nx;
                                rd_idx <= wd_cur;
                                dout_r <= 1'b0;
                            end
                            OP_WRITE: state <= ST_DAT;
                            OP_ERASE: state <= ST_HOLD;
                            OP_EXT: begin
                                unique case (mw_ext_e'(ext_nx))
                                    EX_UNLOCK: begin prog_en <= 1'b1; state <= ST_HOLD; end
                                    EX_LOCK:   begin prog_en <= 1'b0; state <= ST_HOLD; end
                                    EX_FILL:   state <= ST_DAT;
                                    EX_CLEAR:  state <= ST_HOLD;
                                endcase
                            end
                        endcase
                    end else begin
                        bit_cnt <= bit_cnt + 5'd1;
                    end
                end
                ST_DAT: begin
                    data <= data_nx;
                    if (last_dat) state   <= ST_HOLD;
                    else          bit_cnt <= bit_cnt + 5'd1;
                end
                ST_READ: begin
                    dout_r <= rd_word[rd_bit];
                    if (rd_idx == 5'd1) begin
                        rptr   <= rptr_inc;
                        rd_idx <= wd_cur;
                    end else begin
                        rd_idx <= rd_idx - 5'd1;
                    end
                end
                ST_STAT: state <= ST_STAT;
                ST_HOLD: state <= ST_HOLD;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs and array strobes
    always_comb begin
        wr_en     = 1'b0;
        fill_en   = 1'b0;
        wr_word   = data_nx;
        wr_addr   = addr;
        fill_word = data_nx;
        sdout     = 1'b0;
        sdout_oe  = 1'b0;
        rd_active = 1'b0;
        unique case (state)
            ST_ADR: begin
                if (last_adr && can_prog) begin
                    if (mw_op_e'(opc) == OP_ERASE) begin
                        wr_en   = 1'b1;
                        wr_word = 16'hFFFF;
                        wr_addr = waddr_nx;
                    end else if (mw_op_e'(opc) == OP_EXT && mw_ext_e'(ext_nx) == EX_CLEAR
                                 && supply_ok) begin
                        fill_en   = 1'b1;
                        fill_word = 16'hFFFF;
                    end
                end
            end
            ST_DAT: begin
                if (last_dat && can_prog) begin
                    if (mw_op_e'(opc) == OP_WRITE)
                        wr_en = 1'b1;
                    else if (mw_ext_e'(ext_now) == EX_FILL && supply_ok)
                        fill_en = 1'b1;
                end
            end
            ST_READ: begin
                sdout     = dout_r;
                sdout_oe  = 1'b1;
                rd_active = 1'b1;
            end
            ST_STAT: begin
                sdout    = !busy;
                sdout_oe = 1'b1;
            end
            ST_IDLE, ST_OPC, ST_HOLD: begin
                sdout_oe = 1'b0;
            end
            default: sdout_oe = 1'b0;
        endcase
        tmr_start = wr_en | fill_en;
    end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic sel,
    input logic supply_ok,
    input logic sk_rise,
    input logic cs_rise,
    input logic busy,
    input logic prog_en,
    input logic wr_en,
    input logic fill_en,
    input logic rd_active,
    input logic sdout,
    input logic sdout_oe
);

    p_oe_needs_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sdout_oe |-> $past(sel));

    p_read_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active) && !$past(sk_rise)) |-> $stable(sdout));

    p_prog_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || fill_en) |-> (prog_en && !busy));

    p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, fill_en}));

    p_fill_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> supply_ok);

    p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || fill_en) |=> busy);

    p_late_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !busy) |=> !sdout_oe);

endmodule

bind mw_eeprom mw_eeprom_chk chk_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .supply_ok(supply_ok),
    .sk_rise(sk_rise), .cs_rise(cs_rise), .busy(busy), .prog_en(prog_en),
    .wr_en(wr_en), .fill_en(fill_en), .rd_active(rd_active),
    .sdout(sdout), .sdout_oe(sdout_oe)
);

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb_top;

    localparam int BYTE_AW     = 9;
    localparam int PROG_CYCLES = 100;
    localparam int CS_LOW_MIN  = 3;
    localparam int NB          = 1 << BYTE_AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdin = 1'b0, org_wide = 1'b0, supply_ok = 1'b0;
    logic sdout, sdout_oe;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] m [NB];

    always #2.5 clk = ~clk;

    mw_eeprom #(.BYTE_AW(BYTE_AW), .PROG_CYCLES(PROG_CYCLES), .CS_LOW_MIN(CS_LOW_MIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdin(sdin),
        .org_wide(org_wide), .supply_ok(supply_ok), .sdout(sdout), .sdout_oe(sdout_oe)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_bit(input logic b, output logic o);
        sdin = b; sclk = 1'b0;
        tick(2);
        sclk = 1'b1;
        tick(1);
        o = sdout;
        tick(1);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        logic o;
        for (int i = n - 1; i >= 0; i--) sk_bit(v[i], o);
    endtask

    task automatic cs_up();
        sclk = 1'b0; sel = 1'b1;
        tick(2);
    endtask

    task automatic cs_down();
        sel = 1'b0; sclk = 1'b0; sdin = 1'b0;
        tick(CS_LOW_MIN + 2);
    endtask

    function automatic int aw(input logic o);
        return o ? BYTE_AW - 1 : BYTE_AW;
    endfunction

    function automatic logic [15:0] exp_word(input logic o, input int a);
        int w;
        w = o ? (a % (NB / 2)) : (a % NB);
        return o ? {m[2*w], m[2*w+1]} : {8'h00, m[w]};
    endfunction

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) ^ (a >> 3));
    endfunction

    task automatic model_write(input logic o, input int a, input logic [15:0] d);
        if (o) begin m[2*a] = d[15:8]; m[2*a+1] = d[7:0]; end
        else m[a] = d[7:0];
    endtask

    task automatic do_write(input logic o, input int a, input logic [15:0] d);
        org_wide = o;
        cs_up();
        send(16'b101, 3);
        send(16'(a), aw(o));
        send(d, o ? 16 : 8);
        cs_down();
        tick(PROG_CYCLES + 2);
    endtask

    task automatic do_erase(input logic o, input int a);
        org_wide = o;
        cs_up();
        send(16'b111, 3);
        send(16'(a), aw(o));
        cs_down();
        tick(PROG_CYCLES + 2);
    endtask

    task automatic do_ext(input logic o, input logic [1:0] s, input logic [15:0] d);
        org_wide = o;
        cs_up();
        send(16'b100, 3);
        send(16'(s), 2);
        send(16'h0, aw(o) - 2);
        if (s == 2'b01) send(d, o ? 16 : 8);
        cs_down();
        tick(PROG_CYCLES + 2);
    endtask

    task automatic read_check(input logic o, input int a, input int n, input int lead,
                              input string rq);
        logic b;
        logic [15:0] w;
        org_wide = o;
        cs_up();
        send(16'h0, lead);
        send(16'b110, 3);
        send(16'(a >> 1), aw(o) - 1);
        sk_bit(1'(a), b);
        check("R4 dummy zero with drive", {30'h0, sdout_oe, b}, 32'h2);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int j = 0; j < (o ? 16 : 8); j++) begin
                sk_bit(1'b0, b);
                w = {w[14:0], b};
            end
            check(rq, {16'h0, w}, {16'h0, exp_word(o, a + k)});
        end
        cs_down();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic b;
        int polls;
        for (int i = 0; i < NB; i++) m[i] = 8'hFF;
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        check("R1 output disabled", {31'h0, sdout_oe}, 32'h0);
        read_check(1'b0, 0, 4, 0, "R1 erased content");

        // R6 locked write ignored
        do_write(1'b0, 5, 16'h12);
        read_check(1'b0, 5, 1, 0, "R6 locked write");

        do_ext(1'b0, 2'b11, 16'h0);

        // R9 fill with supply low ignored
        supply_ok = 1'b0;
        do_ext(1'b0, 2'b01, 16'h3C);
        read_check(1'b0, 0, 2, 0, "R9 fill without supply");

        // R7 sweep of every byte
        for (int a = 0; a < NB; a++) begin
            do_write(1'b0, a, {8'h00, pat(a)});
            model_write(1'b0, a, {8'h00, pat(a)});
        end
        // R5 full stream with wrap
        read_check(1'b0, 0, NB + 1, 0, "R5 byte stream");
        // R3 word view of the same content
        read_check(1'b1, 0, NB / 2 + 1, 0, "R3 word stream");

        // R2 leading zeros skipped
        read_check(1'b0, 77, 2, 3, "R2 leading zeros");

        // R8 erase of a 16-bit word
        do_erase(1'b1, 3);
        model_write(1'b1, 3, 16'hFFFF);
        read_check(1'b1, 2, 3, 0, "R8 erase word");

        // R7 16-bit write
        do_write(1'b1, 16, 16'hBEEF);
        model_write(1'b1, 16, 16'hBEEF);
        read_check(1'b1, 16, 1, 0, "R7 word write");
        read_check(1'b0, 32, 2, 0, "R3 byte order");

        // R2 abandoned write
        org_wide = 1'b0;
        cs_up();
        send(16'b101, 3);
        send(16'd30, 9);
        send(16'hA, 4);
        cs_down();
        tick(PROG_CYCLES + 2);
        read_check(1'b0, 30, 1, 0, "R2 abandoned write");

        // R11 status poll, R10 second command during busy
        org_wide = 1'b0;
        cs_up();
        send(16'b101, 3);
        send(16'd9, 9);
        send(16'h77, 8);
        model_write(1'b0, 9, 16'h77);
        cs_down();
        cs_up();
        send(16'b101, 3);
        send(16'd11, 9);
        send(16'h22, 8);
        cs_down();
        sel = 1'b1;
        tick(1);
        check("R11 busy status", {30'h0, sdout_oe, sdout}, 32'h2);
        polls = 0;
        while (sdout !== 1'b1 && polls < PROG_CYCLES + 10) begin
            tick(1);
            polls++;
        end
        check("R11 ready status", {30'h0, sdout_oe, sdout}, 32'h3);
        cs_down();
        tick(PROG_CYCLES + 2);
        read_check(1'b0, 9, 1, 0, "R7 write before poll");
        read_check(1'b0, 11, 1, 0, "R10 write during busy");

        // R12 select raised after the timer
        do_write(1'b0, 40, 16'h5A);
        model_write(1'b0, 40, 16'h5A);
        sel = 1'b1;
        tick(2);
        check("R12 no late status", {31'h0, sdout_oe}, 32'h0);
        cs_down();

        // R6 lock then write
        do_ext(1'b0, 2'b00, 16'h0);
        do_write(1'b0, 20, 16'h99);
        do_erase(1'b0, 21);
        read_check(1'b0, 20, 2, 0, "R6 locked program");

        // R9 fill and clear with supply high
        do_ext(1'b0, 2'b11, 16'h0);
        supply_ok = 1'b1;
        do_ext(1'b1, 2'b01, 16'hC3A5);
        for (int i = 0; i < NB; i++) m[i] = (i % 2 == 0) ? 8'hC3 : 8'hA5;
        read_check(1'b0, 256, 4, 0, "R9 fill pattern");
        do_ext(1'b0, 2'b10, 16'h0);
        for (int i = 0; i < NB; i++) m[i] = 8'hFF;
        read_check(1'b1, 127, 2, 0, "R9 clear all");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule